// File: doc/BRIEF.md
# LED Driver Fault and Power Mode Controller

This block is the operating-mode sequencer of a three-string LED driver. It decides when the boost converters and LED current sinks may run. Its inputs are the supply monitors, the per-string and chip-wide fault detectors, the die temperature, a comparator on the external retry capacitor, and the effective dimming signals. The operating modes are Reset, Sleep, Active, Adaptive thermal and Hiccup. A fault on one string stops only that string. An overcurrent or a critical over-temperature event stops every string.

Recovery runs as a retry loop. While a fault is pending, the capacitor is discharged and then charged again. Once the capacitor reaches its threshold with no fault present, a fixed recovery interval is counted before the strings resume. When the die is hot but below the critical level, the block reports a percentage that lowers the peak LED current in steps.

The interrupt is a pull-low request for an open-drain pad, so several devices can share one wired-OR line. The status register that the set pulses feed, and its bus access, sit outside this block.

Top module: `ledfm_mode_ctrl`

## Requirements
- R1: When `rst_n` is low or `por` is high, `mode` is Reset (0) after the next edge. In Reset all `ch_en` bits are 0, `int_pull` is 0 and `derate_pct` is 100. From Reset the block moves to Sleep (1) at the first edge where `por` is low.
- R2: From Sleep the block moves to Active (2) at the next edge when any `pwm_eff` bit is high and `uvlo` is low. It stays in Sleep while `uvlo` is high.
- R3: In Active or Adaptive thermal, when all `pwm_eff` bits are low for `SLEEP_CYC` consecutive edges, `mode` becomes Sleep at the last of those edges. Any high sample restarts the count.
- R4: `uvlo` high in Active or Adaptive thermal moves the block to Sleep at the next edge. It asserts no `int_pull` and gives no set pulse.
- R5: Active moves to Adaptive thermal (3) when `temp_hot` and `adapt_en` are both high. Adaptive thermal returns to Active when either of them is low.
- R6: In Adaptive thermal, `derate_pct` equals 100 − 3·`temp_code`. In every other mode it equals 100.
- R7: In Active or Adaptive thermal, a fault (any `ovp_flag` or `short_flag` bit, `ocp_flag`, or `temp_crit`) raises `int_pull` in the same cycle. `mode` becomes Hiccup (4) at the next edge.
- R8: In Active, Adaptive thermal and Hiccup, each fault input drives its matching set pulse (`ovp_set[n]`, `short_set[n]`, `ocp_set`, `therm_set`) in the same cycle. In Reset and Sleep no set pulse is given.
- R9: An `ovp_flag[n]` or `short_flag[n]` clears only `ch_en[n]`. Inside Hiccup that string stays off, even after the flag drops, until Active is re-entered. Healthy strings stay enabled.
- R10: `ocp_flag` or `temp_crit` clears all `ch_en` bits. Once Hiccup has been entered through one of them, all strings stay off until Active is re-entered.
- R11: Hiccup starts with `hic_charge` low. It raises `hic_charge` once `hic_done` is low. When `hic_done` rises while a fault is pending, `hic_charge` drops and a new period starts.
- R12: When `hic_done` rises with no fault pending, `mode` becomes Active after `RECOV_CYC` further edges and `int_pull` drops. A fault during that interval restarts the period.
- R13: After a Hiccup entered through `temp_crit`, the fault stays pending while `temp_hot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por | input | 1 | Supply below power-on threshold |
| uvlo | input | 1 | High-voltage input below lockout level |
| ovp_flag | input | NCH | Per-string overvoltage / open string |
| short_flag | input | NCH | Per-string short / coil current limit |
| ocp_flag | input | 1 | Reference overcurrent |
| temp_hot | input | 1 | Die above derating threshold |
| temp_crit | input | 1 | Die above critical threshold |
| temp_code | input | TCODE_W | Number of full temperature steps above the derating threshold |
| adapt_en | input | 1 | Adaptive thermal derating allowed |
| hic_done | input | 1 | Retry capacitor reached its threshold |
| pwm_eff | input | NCH | Effective dimming signals |
| ch_en | output | NCH | Converter and current-sink enable per string |
| int_pull | output | 1 | Pull-low request for the open-drain interrupt |
| hic_charge | output | 1 | Charge the retry capacitor (low discharges it) |
| ovp_set | output | NCH | Overvoltage status set pulse per string |
| short_set | output | NCH | Short status set pulse per string |
| ocp_set | output | 1 | Overcurrent status set pulse |
| therm_set | output | 1 | Over-temperature status set pulse |
| derate_pct | output | 7 | Peak current scale in percent |
| mode | output | 3 | Current mode: 0 Reset, 1 Sleep, 2 Active, 3 Adaptive thermal, 4 Hiccup |

## Verification
The bound checker watches several relations on every cycle. A power-on request always leads to Reset. Reset and Sleep stay silent on the interrupt and the set pulses. A faulted string's enable is never high while its flag is. A global fault disables every string. Hiccup always holds the interrupt, and a seen fault always enters Hiccup. The bench scenarios cover what needs history to show. That includes the exact idle count and its restart, the fault masks held after a flag drops, and the retry loop through discharge and recharge. It also includes a fault cutting the recovery interval short, and the thermal retry that persists while the die stays hot.

// File: rtl/ledfm_pkg.sv
// Shared types for the LED fault and power mode controller.
// Assumes the mode encoding below is also decoded by the status logic.
package ledfm_pkg;
    typedef enum logic [2:0] {
        MD_RESET  = 3'd0,
        MD_SLEEP  = 3'd1,
        MD_ACTIVE = 3'd2,
        MD_THERM  = 3'd3,
        MD_HICCUP = 3'd4
    } ledfm_mode_e;

    typedef enum logic [1:0] {
        HP_DISCH  = 2'd0,
        HP_CHARGE = 2'd1,
        HP_RECOV  = 2'd2
    } ledfm_hphase_e;

    localparam int PCT_W       = 7;
    localparam int DERATE_FULL = 100;
endpackage

// File: rtl/ledfm_run_timer.sv
// Run-length timer: counts consecutive cycles with run high.
// expire is high in the LIMIT-th consecutive run cycle; the count restarts after it.
// Assumes LIMIT >= 1.
module ledfm_run_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == LAST);

    // Count run cycles; clear on reset, idle or expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ledfm_derate.sv
// Thermal derating: reports the peak current scale in percent.
// Assumes code counts full temperature steps above the derating threshold.
module ledfm_derate #(
    parameter int CODE_W = 3,
    parameter int STEP   = 3
) (
    input  logic                       en,
    input  logic [CODE_W-1:0]          code,
    output logic [ledfm_pkg::PCT_W-1:0] pct
);
    import ledfm_pkg::*;

    // Subtract one step per code unit while derating is in force.
    always_comb begin
        if (en) begin
            pct = PCT_W'(DERATE_FULL - STEP * int'(code));
        end else begin
            pct = PCT_W'(DERATE_FULL);
        end
    end
endmodule

// File: rtl/ledfm_chan_gate.sv
// Per-string enable gating. Holds the fault masks of one retry episode.
// Assumes latch_en is high exactly while the next mode is Hiccup.
module ledfm_chan_gate #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           latch_en,
    input  logic           run_ok,
    input  logic [NCH-1:0] ovp_now,
    input  logic [NCH-1:0] short_now,
    input  logic           glob_now,
    output logic [NCH-1:0] ch_en
);
    logic glob_q;

    // Remember a chip-wide fault for the whole episode.
    always_ff @(posedge clk) begin
        if (!rst_n || !latch_en) begin
            glob_q <= 1'b0;
        end else begin
            glob_q <= glob_q | glob_now;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_str
        logic kill_q;

        // Remember a string fault for the whole episode.
        always_ff @(posedge clk) begin
            if (!rst_n || !latch_en) begin
                kill_q <= 1'b0;
            end else begin
                kill_q <= kill_q | ovp_now[n] | short_now[n];
            end
        end

        assign ch_en[n] = run_ok && !kill_q && !ovp_now[n] && !short_now[n]
                          && !glob_q && !glob_now;
    end
endmodule

// File: rtl/ledfm_mode_ctrl.sv
// Operating mode controller of a multi-string LED driver.
// Sequences Reset, Sleep, Active, Adaptive thermal and Hiccup modes, gates the
// per-string enables, requests the shared open-drain interrupt and emits set
// pulses for the status register. Assumes all inputs are synchronous to clk.
module ledfm_mode_ctrl #(
    parameter int          NCH       = 3,
    parameter int          TCODE_W   = 3,
    parameter int unsigned SLEEP_CYC = 32_000_000,
    parameter int unsigned RECOV_CYC = 6_400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               por,
    input  logic               uvlo,
    input  logic [NCH-1:0]     ovp_flag,
    input  logic [NCH-1:0]     short_flag,
    input  logic               ocp_flag,
    input  logic               temp_hot,
    input  logic               temp_crit,
    input  logic [TCODE_W-1:0] temp_code,
    input  logic               adapt_en,
    input  logic               hic_done,
    input  logic [NCH-1:0]     pwm_eff,
    output logic [NCH-1:0]     ch_en,
    output logic               int_pull,
    output logic               hic_charge,
    output logic [NCH-1:0]     ovp_set,
    output logic [NCH-1:0]     short_set,
    output logic               ocp_set,
    output logic               therm_set,
    output logic [6:0]         derate_pct,
    output logic [2:0]         mode
);
    import ledfm_pkg::*;

    ledfm_mode_e   md_q, md_d;
    ledfm_hphase_e hp_q, hp_d;
    logic          therm_q;
    logic          idle_exp, rec_exp;

    wire pwm_any   = |pwm_eff;
    wire glob_now  = ocp_flag | temp_crit;
    wire fault_now = (|ovp_flag) | (|short_flag) | glob_now;
    wire fault_pend = fault_now | (therm_q & temp_hot);
    wire running   = (md_q == MD_ACTIVE) || (md_q == MD_THERM);
    wire watch     = running || (md_q == MD_HICCUP);
    wire in_recov  = (md_q == MD_HICCUP) && (hp_q == HP_RECOV);

    // Next mode and retry phase.
    always_comb begin
        md_d = md_q;
        hp_d = hp_q;
        unique case (md_q)
            MD_RESET: if (!por) md_d = MD_SLEEP;
            MD_SLEEP: if (pwm_any && !uvlo) md_d = MD_ACTIVE;
            MD_ACTIVE, MD_THERM: begin
                if (uvlo) begin
                    md_d = MD_SLEEP;
                end else if (fault_now) begin
                    md_d = MD_HICCUP;
                    hp_d = HP_DISCH;
                end else if (idle_exp) begin
                    md_d = MD_SLEEP;
                end else if (md_q == MD_ACTIVE && temp_hot && adapt_en) begin
                    md_d = MD_THERM;
                end else if (md_q == MD_THERM && !(temp_hot && adapt_en)) begin
                    md_d = MD_ACTIVE;
                end
            end
            MD_HICCUP: begin
                unique case (hp_q)
                    HP_DISCH:  if (!hic_done) hp_d = HP_CHARGE;
                    HP_CHARGE: if (hic_done) hp_d = fault_pend ? HP_DISCH : HP_RECOV;
                    HP_RECOV: begin
                        if (fault_pend) hp_d = HP_DISCH;
                        else if (rec_exp) md_d = MD_ACTIVE;
                    end
                    default:   hp_d = HP_DISCH;
                endcase
            end
            default: md_d = MD_RESET;
        endcase
        if (por) md_d = MD_RESET;
    end

    // Mode and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md_q <= MD_RESET;
            hp_q <= HP_DISCH;
        end else begin
            md_q <= md_d;
            hp_q <= hp_d;
        end
    end

    // Remember that the episode was caused by a critical temperature.
    always_ff @(posedge clk) begin
        if (!rst_n || md_d != MD_HICCUP) begin
            therm_q <= 1'b0;
        end else begin
            therm_q <= therm_q | temp_crit;
        end
    end

    ledfm_run_timer #(.LIMIT(SLEEP_CYC)) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running && !pwm_any),
        .expire (idle_exp)
    );

    ledfm_run_timer #(.LIMIT(RECOV_CYC)) u_recov (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (in_recov && !fault_pend),
        .expire (rec_exp)
    );

    ledfm_chan_gate #(.NCH(NCH)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_en  (md_d == MD_HICCUP),
        .run_ok    (watch),
        .ovp_now   (ovp_flag),
        .short_now (short_flag),
        .glob_now  (glob_now),
        .ch_en     (ch_en)
    );

    ledfm_derate #(.CODE_W(TCODE_W), .STEP(3)) u_derate (
        .en   (md_q == MD_THERM),
        .code (temp_code),
        .pct  (derate_pct)
    );

    assign int_pull   = (md_q == MD_HICCUP) || (running && fault_now);
    assign hic_charge = (md_q == MD_HICCUP) && (hp_q != HP_DISCH);
    assign ovp_set    = ovp_flag & {NCH{watch}};
    assign short_set  = short_flag & {NCH{watch}};
    assign ocp_set    = ocp_flag & watch;
    assign therm_set  = temp_crit & watch;
    assign mode       = md_q;
endmodule

// File: rtl/ledfm_mode_chk.sv
// Protocol checker for ledfm_mode_ctrl, attached by bind.
// Assumes the mode encoding of ledfm_pkg.
module ledfm_mode_chk #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           por,
    input logic           uvlo,
    input logic [NCH-1:0] ovp_flag,
    input logic [NCH-1:0] short_flag,
    input logic           ocp_flag,
    input logic           temp_crit,
    input logic [NCH-1:0] ch_en,
    input logic           int_pull,
    input logic [NCH-1:0] ovp_set,
    input logic [NCH-1:0] short_set,
    input logic           ocp_set,
    input logic           therm_set,
    input logic [6:0]     derate_pct,
    input logic [2:0]     mode
);
    import ledfm_pkg::*;

    wire run_md = (mode == MD_ACTIVE) || (mode == MD_THERM);
    wire any_fault = (|ovp_flag) || (|short_flag) || ocp_flag || temp_crit;

    // R1
    por_to_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por |=> mode == MD_RESET);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MD_RESET |-> (ch_en == '0) && !int_pull);
    // R4
    uvlo_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_md && uvlo && !por) |=> mode == MD_SLEEP);
    // R6
    derate_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != MD_THERM |-> derate_pct == 7'd100);
    // R7
    fault_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_md && any_fault) |-> int_pull);
    // R7
    fault_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_md && any_fault && !uvlo && !por) |=> mode == MD_HICCUP);
    // R8
    quiet_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RESET || mode == MD_SLEEP) |->
        (ovp_set == '0) && (short_set == '0) && !ocp_set && !therm_set);
    // R9
    str_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en & (ovp_flag | short_flag)) == '0);
    // R10
    glob_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_flag || temp_crit) |-> ch_en == '0);
    // R12
    hic_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MD_HICCUP |-> int_pull);
endmodule

bind ledfm_mode_ctrl ledfm_mode_chk #(.NCH(NCH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .por        (por),
    .uvlo       (uvlo),
    .ovp_flag   (ovp_flag),
    .short_flag (short_flag),
    .ocp_flag   (ocp_flag),
    .temp_crit  (temp_crit),
    .ch_en      (ch_en),
    .int_pull   (int_pull),
    .ovp_set    (ovp_set),
    .short_set  (short_set),
    .ocp_set    (ocp_set),
    .therm_set  (therm_set),
    .derate_pct (derate_pct),
    .mode       (mode)
);

// File: tb/ledfm_mode_ctrl_tb_top.sv
// Bench for ledfm_mode_ctrl: directed mode walks plus seeded random fault mixes.
module ledfm_mode_ctrl_tb_top;
    localparam int CLK_P = 10;
    localparam int NCH   = 3;
    localparam int SLP   = 40;
    localparam int REC   = 12;

    logic           clk = 1'b0;
    logic           rst_n, por, uvlo, ocp_flag, temp_hot, temp_crit, adapt_en, hic_done;
    logic [NCH-1:0] ovp_flag, short_flag, pwm_eff;
    logic [2:0]     temp_code;
    logic [NCH-1:0] ch_en, ovp_set, short_set;
    logic           int_pull, hic_charge, ocp_set, therm_set;
    logic [6:0]     derate_pct;
    logic [2:0]     mode;

    int checks = 0;
    int errs   = 0;

    always #(CLK_P/2) clk = ~clk;

    ledfm_mode_ctrl #(.NCH(NCH), .TCODE_W(3), .SLEEP_CYC(SLP), .RECOV_CYC(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .por(por), .uvlo(uvlo), .ovp_flag(ovp_flag),
        .short_flag(short_flag), .ocp_flag(ocp_flag), .temp_hot(temp_hot),
        .temp_crit(temp_crit), .temp_code(temp_code), .adapt_en(adapt_en),
        .hic_done(hic_done), .pwm_eff(pwm_eff), .ch_en(ch_en), .int_pull(int_pull),
        .hic_charge(hic_charge), .ovp_set(ovp_set), .short_set(short_set),
        .ocp_set(ocp_set), .therm_set(therm_set), .derate_pct(derate_pct), .mode(mode)
    );

    function automatic int exp_derate(input int code);
        return 100 - 3 * code;
    endfunction

    function automatic int exp_en(input logic [NCH-1:0] o, input logic [NCH-1:0] s,
                                  input logic glob);
        return glob ? 0 : int'(~(o | s) & {NCH{1'b1}});
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd11));
        rst_n = 0; por = 0; uvlo = 0; ocp_flag = 0; temp_hot = 0; temp_crit = 0;
        adapt_en = 0; hic_done = 0; ovp_flag = '0; short_flag = '0; pwm_eff = '0;
        temp_code = '0;
        tick(2);
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset enables", int'(ch_en), 0);
        check("R1 reset int", int'(int_pull), 0);
        check("R1 reset derate", int'(derate_pct), 100);
        rst_n = 1;
        tick(1);
        check("R1 leave reset", int'(mode), 1);

        // R2 wake-up blocked by uvlo, then allowed
        uvlo = 1; pwm_eff = 3'b001;
        tick(1);
        check("R2 uvlo holds sleep", int'(mode), 1);
        uvlo = 0;
        tick(1);
        check("R2 wake", int'(mode), 2);
        check("R2 enables", int'(ch_en), 7);

        // R3 idle count with restart
        pwm_eff = '0;
        tick(SLP - 1);
        check("R3 before timeout", int'(mode), 2);
        pwm_eff = 3'b010;
        tick(1);
        pwm_eff = '0;
        tick(SLP - 1);
        check("R3 restarted count", int'(mode), 2);
        tick(1);
        check("R3 timeout sleep", int'(mode), 1);
        pwm_eff = 3'b111;
        tick(1);
        check("R2 rewake", int'(mode), 2);

        // R4 uvlo in active
        uvlo = 1;
        #1;
        check("R4 no int", int'(int_pull), 0);
        check("R4 no set", int'({ovp_set, short_set, ocp_set, therm_set}), 0);
        tick(1);
        check("R4 to sleep", int'(mode), 1);
        check("R4 int after", int'(int_pull), 0);
        uvlo = 0;
        tick(1);
        check("R4 back active", int'(mode), 2);

        // R5 R6 thermal derating
        temp_hot = 1; temp_code = 3'd5;
        tick(1);
        check("R5 disabled stays active", int'(mode), 2);
        check("R6 no derate in active", int'(derate_pct), 100);
        adapt_en = 1;
        tick(1);
        check("R5 enter therm", int'(mode), 3);
        check("R6 derate code5", int'(derate_pct), exp_derate(5));
        for (int i = 0; i < 8; i++) begin
            temp_code = 3'($urandom_range(0, 7));
            #1;
            check("R6 random derate", int'(derate_pct), exp_derate(int'(temp_code)));
        end
        temp_code = 3'd7;
        #1;
        check("R6 max derate", int'(derate_pct), 79);
        temp_hot = 0;
        tick(1);
        check("R5 back active", int'(mode), 2);
        check("R6 full again", int'(derate_pct), 100);

        // R7 R8 R9 R10 random fault mixes seen between edges
        for (int i = 0; i < 60; i++) begin
            logic [NCH-1:0] o, s;
            logic oc, cr;
            o  = NCH'($urandom_range(0, 7));
            s  = NCH'($urandom_range(0, 7));
            oc = ($urandom_range(0, 7) == 0);
            cr = ($urandom_range(0, 7) == 0);
            ovp_flag = o; short_flag = s; ocp_flag = oc; temp_crit = cr;
            #1;
            check("R9 R10 random enables", int'(ch_en), exp_en(o, s, oc | cr));
            check("R7 random int", int'(int_pull), int'((|o) | (|s) | oc | cr));
            check("R8 random sets", int'({ovp_set, short_set, ocp_set, therm_set}),
                  int'({o, s, oc, cr}));
            ovp_flag = '0; short_flag = '0; ocp_flag = 0; temp_crit = 0;
            tick(1);
        end
        check("R7 still active", int'(mode), 2);

        // R9 R11 R12 string fault with one retry
        ovp_flag = 3'b010;
        #1;
        check("R7 int at once", int'(int_pull), 1);
        check("R9 only string1 off", int'(ch_en), 5);
        tick(1);
        check("R7 hiccup", int'(mode), 4);
        check("R11 discharge first", int'(hic_charge), 0);
        tick(1);
        check("R11 charging", int'(hic_charge), 1);
        hic_done = 1;
        tick(1);
        check("R11 restart discharge", int'(hic_charge), 0);
        hic_done = 0;
        tick(1);
        check("R11 recharge", int'(hic_charge), 1);
        ovp_flag = '0;
        #1;
        check("R9 mask held", int'(ch_en), 5);
        hic_done = 1;
        tick(1);
        tick(REC - 1);
        check("R12 recovery not done", int'(mode), 4);
        check("R12 int held", int'(int_pull), 1);
        tick(1);
        check("R12 resumed", int'(mode), 2);
        check("R12 int released", int'(int_pull), 0);
        check("R9 all back", int'(ch_en), 7);
        hic_done = 0;
        tick(1);

        // R10 R12 global fault, fault during recovery restarts
        ocp_flag = 1;
        tick(1);
        ocp_flag = 0;
        tick(1);
        hic_done = 1;
        tick(1);
        tick(3);
        short_flag = 3'b001;
        tick(1);
        check("R12 fault restarts", int'(hic_charge), 0);
        check("R12 still hiccup", int'(mode), 4);
        short_flag = '0;
        #1;
        check("R10 global mask held", int'(ch_en), 0);
        hic_done = 0;
        tick(1);
        hic_done = 1;
        tick(1);
        tick(REC);
        check("R12 resumed after restart", int'(mode), 2);
        hic_done = 0;
        tick(1);

        // R13 thermal retry while hot
        temp_hot = 1; temp_crit = 1;
        #1;
        check("R8 therm set", int'(therm_set), 1);
        tick(1);
        check("R13 hiccup", int'(mode), 4);
        temp_crit = 0;
        tick(1);
        hic_done = 1;
        tick(1);
        check("R13 hot keeps retrying", int'(hic_charge), 0);
        temp_hot = 0; hic_done = 0;
        tick(1);
        hic_done = 1;
        tick(1);
        tick(REC);
        check("R13 resumed when cool", int'(mode), 2);
        hic_done = 0;

        // R8 no set pulse in sleep
        uvlo = 1;
        tick(1);
        ovp_flag = 3'b111; ocp_flag = 1;
        #1;
        check("R8 sleep no set", int'({ovp_set, short_set, ocp_set, therm_set}), 0);
        check("R8 sleep no int", int'(int_pull), 0);
        ovp_flag = '0; ocp_flag = 0; uvlo = 0;
        tick(1);

        // R1 power-on request
        por = 1;
        tick(1);
        check("R1 por reset", int'(mode), 0);
        check("R1 por enables", int'(ch_en), 0);
        por = 0;
        tick(1);
        check("R1 por release", int'(mode), 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule